// File: doc/BRIEF.md
# Configuration Port Lock and Logical Device Register File

This block is the host-facing configuration front end of a multi-function I/O peripheral. It sits on a plain byte-wide I/O bus with an address, a write strobe, a read strobe, write data and read data. It decodes a pair of neighbouring port addresses: the lower one is the index port and the one above it is the data port. A strap input picks which pair is live.

After reset the configuration space is locked. Software opens it by writing a two-byte entry key to the index port and closes it with a one-byte exit key. While the space is open, an index write selects a register and data-port accesses read or write that register. One register chooses which of the logical devices the per-device registers act on. Each logical device has an enable flag and a 16-bit I/O base. Both are driven out of the block to the address decoders of the device functions downstream.

Top module: `sio_cfg_port`

## Requirements
- R1: With `strap_alt` = 0 the index port is at address 0x004E and the data port at 0x004F. With `strap_alt` = 1 they are at 0x002E and 0x002F. Accesses to any other address, including the pair that is not selected, change no state and read as 0x00.
- R2: While locked, the space unlocks only after two back-to-back index-port writes of 0xA5. `cfg_unlocked` rises in the cycle after the second write.
- R3: While locked, an index-port write of any byte other than 0xA5 clears the entry-key progress. A single 0xA5 write, or 0xA5 followed by another byte and then 0xA5, leaves the space locked.
- R4: While unlocked, an index-port write of 0xAA relocks the space. `cfg_unlocked` falls in the next cycle, and a fresh two-write key is then needed.
- R5: While locked, data-port writes are ignored and data-port reads return 0xFF.
- R6: While unlocked, an index-port write of any byte other than 0xAA becomes the current register index. Data-port accesses then act on that index.
- R7: Index 0x07 is the device select. The low two bits of the written byte pick logical device 0 to 3, and a read returns those two bits with the upper six bits at 0.
- R8: For the selected device, bit 0 of index 0x30 is the enable flag (read back with bits 7:1 at 0). Index 0x60 holds base bits 15:8 and index 0x61 holds base bits 7:0. Device i drives `ldev_en[i]` and `ldev_base[16*i +: 16]`.
- R9: While unlocked, a data-port read returns the value last written for the current index and the selected device. Indices with no register read as 0x00 and ignore writes. `io_rdata` is combinational and is valid in the same cycle as `io_rd`.
- R10: After reset the space is locked, every enable is 0, every base is 0x0000, the index is 0x00 and device 0 is selected.
- R11: Within one unlocked session a device can be disabled, given a new base and re-enabled, and the other devices keep their settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Port pair select: 0 for 0x4E/0x4F, 1 for 0x2E/0x2F |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| cfg_unlocked | output | 1 | High while configuration space is open |
| ldev_en | output | 4 | Enable flag of each logical device |
| ldev_base | output | 64 | I/O base of each logical device, 16 bits each |

## Verification
The assertions check on every cycle that an unlock is always preceded by a 0xA5 index write, that the exit key always relocks, that locked data writes leave every enable and base unchanged and locked data reads give 0xFF, and that reset clears the outputs. Key sequences broken by other bytes, register selection and readback through the index, the strap moving the port pair, and the per-device disable, rebase and re-enable flow can be shown only by the bench's scenarios. The bench compares these against its reference model every clock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'hA5;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IDX_DEVSEL = 8'h07;
  localparam logic [7:0] IDX_ENABLE = 8'h30;
  localparam logic [7:0] IDX_BASE_H = 8'h60;
  localparam logic [7:0] IDX_BASE_L = 8'h61;
  localparam logic [15:0] PAIR_PRIMARY = 16'h004E;
  localparam logic [15:0] PAIR_ALT     = 16'h002E;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  typedef struct packed {
    logic        en;
    logic [15:0] base;
  } ldev_cfg_t;
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int ADDR_W = 16
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              dat_rd
);
  import sio_cfg_pkg::*;

  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] dat_addr;
  logic              hit_idx;
  logic              hit_dat;

  always_comb begin
    idx_addr = strap_alt ? ADDR_W'(PAIR_ALT) : ADDR_W'(PAIR_PRIMARY);
    dat_addr = idx_addr + ADDR_W'(1);
    hit_idx  = (io_addr == idx_addr);
    hit_dat  = (io_addr == dat_addr);
    idx_wr   = io_wr & hit_idx;
    dat_wr   = io_wr & hit_dat;
    dat_rd   = io_rd & hit_dat;
  end
endmodule

// File: rtl/sio_key_lock.sv
module sio_key_lock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic       idx_load
);
  import sio_cfg_pkg::*;

  logic unlocked_q, unlocked_d;
  logic half_key_q, half_key_d;

  always_comb begin
    unlocked_d = unlocked_q;
    half_key_d = half_key_q;
    idx_load   = 1'b0;
    if (idx_wr) begin
      if (!unlocked_q) begin
        if (wdata == KEY_OPEN) begin
          if (half_key_q) begin
            unlocked_d = 1'b1;
            half_key_d = 1'b0;
          end else begin
            half_key_d = 1'b1;
          end
        end else begin
          half_key_d = 1'b0;
        end
      end else if (wdata == KEY_CLOSE) begin
        unlocked_d = 1'b0;
        half_key_d = 1'b0;
      end else begin
        idx_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      half_key_q <= 1'b0;
    end else if (idx_wr) begin
      unlocked_q <= unlocked_d;
      half_key_q <= half_key_d;
    end
  end

  assign unlocked = unlocked_q;
endmodule

// File: rtl/sio_ldev_regs.sv
module sio_ldev_regs #(
  parameter int NUM_LDEV = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  unlocked,
  input  logic                  idx_load,
  input  logic                  dat_wr,
  input  logic [7:0]            wdata,
  output logic [NUM_LDEV-1:0]   en_o,
  output logic [16*NUM_LDEV-1:0] base_o,
  output logic [7:0]            rd_val
);
  import sio_cfg_pkg::*;

  localparam int SEL_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;

  logic [7:0]       index_q, index_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             cfg_wr;
  logic             wr_sel, wr_en, wr_hi, wr_lo;
  ldev_cfg_t        dev_q [NUM_LDEV];
  ldev_cfg_t        cur;

  always_comb begin
    cfg_wr  = dat_wr & unlocked;
    wr_sel  = cfg_wr & (index_q == IDX_DEVSEL);
    wr_en   = cfg_wr & (index_q == IDX_ENABLE);
    wr_hi   = cfg_wr & (index_q == IDX_BASE_H);
    wr_lo   = cfg_wr & (index_q == IDX_BASE_L);
    index_d = idx_load ? wdata : index_q;
    sel_d   = wr_sel ? wdata[SEL_W-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      sel_q   <= '0;
    end else begin
      if (idx_load) index_q <= index_d;
      if (wr_sel)   sel_q   <= sel_d;
    end
  end

  for (genvar i = 0; i < NUM_LDEV; i++) begin : g_dev
    logic      hit;
    ldev_cfg_t nxt;

    always_comb begin
      hit = (sel_q == SEL_W'(i));
      nxt = dev_q[i];
      if (hit && wr_en) nxt.en         = wdata[0];
      if (hit && wr_hi) nxt.base[15:8] = wdata;
      if (hit && wr_lo) nxt.base[7:0]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dev_q[i] <= '0;
      end else if (hit && (wr_en || wr_hi || wr_lo)) begin
        dev_q[i] <= nxt;
      end
    end

    assign en_o[i]            = dev_q[i].en;
    assign base_o[16*i +: 16] = dev_q[i].base;
  end

  always_comb begin
    cur = dev_q[sel_q];
    unique case (index_q)
      IDX_DEVSEL: rd_val = 8'(sel_q);
      IDX_ENABLE: rd_val = {7'b0, cur.en};
      IDX_BASE_H: rd_val = cur.base[15:8];
      IDX_BASE_L: rd_val = cur.base[7:0];
      default:    rd_val = 8'h00;
    endcase
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int ADDR_W   = 16,
  parameter int NUM_LDEV = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strap_alt,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic                   cfg_unlocked,
  output logic [NUM_LDEV-1:0]    ldev_en,
  output logic [16*NUM_LDEV-1:0] ldev_base
);
  import sio_cfg_pkg::*;

  logic idx_wr, dat_wr, dat_rd;
  logic idx_load;
  logic [7:0] rd_val;

  sio_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .strap_alt (strap_alt),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .idx_wr    (idx_wr),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd)
  );

  sio_key_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .unlocked (cfg_unlocked),
    .idx_load (idx_load)
  );

  sio_ldev_regs #(.NUM_LDEV(NUM_LDEV)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlocked (cfg_unlocked),
    .idx_load (idx_load),
    .dat_wr   (dat_wr),
    .wdata    (io_wdata),
    .en_o     (ldev_en),
    .base_o   (ldev_base),
    .rd_val   (rd_val)
  );

  always_comb begin
    if (!dat_rd)           io_rdata = 8'h00;
    else if (!cfg_unlocked) io_rdata = LOCKED_READ;
    else                   io_rdata = rd_val;
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int ADDR_W   = 16,
  parameter int NUM_LDEV = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   strap_alt,
  input logic [ADDR_W-1:0]      io_addr,
  input logic                   io_wr,
  input logic                   io_rd,
  input logic [7:0]             io_wdata,
  input logic [7:0]             io_rdata,
  input logic                   cfg_unlocked,
  input logic [NUM_LDEV-1:0]    ldev_en,
  input logic [16*NUM_LDEV-1:0] ldev_base
);
  logic [ADDR_W-1:0] ip;
  logic w_idx, w_dat, r_dat;

  assign ip    = strap_alt ? ADDR_W'(16'h002E) : ADDR_W'(16'h004E);
  assign w_idx = io_wr && (io_addr == ip);
  assign w_dat = io_wr && (io_addr == ip + ADDR_W'(1));
  assign r_dat = io_rd && (io_addr == ip + ADDR_W'(1));

  // R2: opening needs a 0xA5 index write in the cycle before
  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(w_idx && io_wdata == 8'hA5));

  // R4: exit key relocks
  assert_exit_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && w_idx && io_wdata == 8'hAA) |=> !cfg_unlocked);

  // R5: locked data writes change nothing
  assert_locked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && w_dat) |=> ($stable(ldev_en) && $stable(ldev_base)));

  // R5: locked data reads give 0xFF
  assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && r_dat) |-> io_rdata == 8'hFF);

  // R10: reset clears outputs
  always_comb begin
    if (!rst_n) begin
      assert_reset_R10: assert (!cfg_unlocked && ldev_en == '0 && ldev_base == '0);
    end
  end
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ADDR_W(ADDR_W), .NUM_LDEV(NUM_LDEV)) u_chk (.*);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_alt;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        cfg_unlocked;
  logic [3:0]  ldev_en;
  logic [63:0] ldev_base;

  always #2 clk = ~clk;

  sio_cfg_port u0 (.*);

  int total = 0;
  int fails = 0;
  string cur_req = "R10";
  bit live = 0;

  // reference model
  bit      m_unl, m_half;
  int      m_idx, m_sel;
  bit      m_en [4];
  int      m_base [4];

  task automatic model_reset();
    m_unl = 0; m_half = 0; m_idx = 0; m_sel = 0;
    foreach (m_en[k]) begin m_en[k] = 0; m_base[k] = 0; end
  endtask

  function automatic int ip_addr();
    return strap_alt ? 'h2E : 'h4E;
  endfunction

  function automatic int model_read(int a);
    if (a != ip_addr() + 1) return 0;
    if (!m_unl) return 'hFF;
    case (m_idx)
      'h07: return m_sel;
      'h30: return m_en[m_sel];
      'h60: return (m_base[m_sel] >> 8) & 'hFF;
      'h61: return m_base[m_sel] & 'hFF;
      default: return 0;
    endcase
  endfunction

  task automatic model_write(int a, int d);
    if (a == ip_addr()) begin
      if (!m_unl) begin
        if (d == 'hA5) begin
          if (m_half) begin m_unl = 1; m_half = 0; end
          else m_half = 1;
        end else m_half = 0;
      end else if (d == 'hAA) begin
        m_unl = 0; m_half = 0;
      end else m_idx = d;
    end else if (a == ip_addr() + 1 && m_unl) begin
      case (m_idx)
        'h07: m_sel = d % 4;
        'h30: m_en[m_sel] = d[0];
        'h60: m_base[m_sel] = (m_base[m_sel] & 'hFF) | (d << 8);
        'h61: m_base[m_sel] = (m_base[m_sel] & 'hFF00) | d;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // compare state outputs against model every clock
  always @(negedge clk) begin
    if (live) begin
      chk(cur_req, "cfg_unlocked", int'(cfg_unlocked), int'(m_unl));
      for (int k = 0; k < 4; k++) begin
        chk(cur_req, "ldev_en", int'(ldev_en[k]), int'(m_en[k]));
        chk(cur_req, "ldev_base", int'(ldev_base[16*k +: 16]), m_base[k]);
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    #0.5;
    io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1'b1;
    @(posedge clk);
    #0.5;
    io_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    #0.5;
    io_addr = 16'(a); io_rd = 1'b1;
    #0.5;
    chk(req, "io_rdata", int'(io_rdata), model_read(a));
    @(posedge clk);
    #0.5;
    io_rd = 1'b0;
  endtask

  task automatic rd_exp(int a, int exp, string req);
    @(negedge clk);
    #0.5;
    io_addr = 16'(a); io_rd = 1'b1;
    #0.5;
    chk(req, "io_rdata", int'(io_rdata), exp);
    @(posedge clk);
    #0.5;
    io_rd = 1'b0;
  endtask

  task automatic set_reg(int ip, int idx, int d);
    wr(ip, idx);
    wr(ip + 1, d);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_alt = 1'b0; io_addr = '0;
    io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state
    cur_req = "R10";
    @(negedge clk);
    chk("R10", "unlocked after reset", int'(cfg_unlocked), 0);
    chk("R10", "enables after reset", int'(ldev_en), 0);
    chk("R10", "bases after reset", int'(ldev_base == 64'd0), 1);
    live = 1;

    // R5: locked data port
    cur_req = "R5";
    rd_exp('h4F, 'hFF, "R5");
    wr('h4F, 'h12);
    rd_exp('h4F, 'hFF, "R5");
    rd_exp('h4E, 'h00, "R1");

    // R3: broken key sequences
    cur_req = "R3";
    wr('h4E, 'hA5);
    wr('h4E, 'h11);
    wr('h4E, 'hA5);
    chk("R3", "A5,11,A5 stays locked", int'(cfg_unlocked), 0);
    wr('h4E, 'h00);
    wr('h4E, 'hA5);
    chk("R3", "single A5 stays locked", int'(cfg_unlocked), 0);
    wr('h4E, 'h3C);

    // R1: wrong pair ignored
    cur_req = "R1";
    wr('h2E, 'hA5);
    wr('h2E, 'hA5);
    chk("R1", "alt pair ignored when strap=0", int'(cfg_unlocked), 0);

    // R2: unlock
    cur_req = "R2";
    wr('h4E, 'hA5);
    wr('h4E, 'hA5);
    chk("R2", "unlocked after two A5", int'(cfg_unlocked), 1);

    // R6 R7 R8 R9: program device 2
    cur_req = "R8";
    set_reg('h4E, 'h07, 'hFE);
    rd_exp('h4F, 'h02, "R7");
    set_reg('h4E, 'h60, 'h03);
    set_reg('h4E, 'h61, 'hF8);
    set_reg('h4E, 'h30, 'h01);
    chk("R8", "dev2 base", int'(ldev_base[47:32]), 'h03F8);
    chk("R8", "dev2 enable", int'(ldev_en[2]), 1);
    wr('h4E, 'h60);
    rd_exp('h4F, 'h03, "R9");
    wr('h4E, 'h61);
    rd_exp('h4F, 'hF8, "R9");
    wr('h4E, 'h30);
    rd_exp('h4F, 'h01, "R6");
    set_reg('h4E, 'h55, 'h77);
    rd_exp('h4F, 'h00, "R9");

    // device 0 programmed, then device 2 reworked
    cur_req = "R11";
    set_reg('h4E, 'h07, 'h00);
    set_reg('h4E, 'h60, 'h02);
    set_reg('h4E, 'h61, 'hE8);
    set_reg('h4E, 'h30, 'h01);
    set_reg('h4E, 'h07, 'h02);
    set_reg('h4E, 'h30, 'h00);
    chk("R11", "dev2 disabled", int'(ldev_en[2]), 0);
    set_reg('h4E, 'h60, 'h02);
    set_reg('h4E, 'h61, 'hF8);
    set_reg('h4E, 'h30, 'h01);
    chk("R11", "dev2 rebased", int'(ldev_base[47:32]), 'h02F8);
    chk("R11", "dev2 re-enabled", int'(ldev_en[2]), 1);
    chk("R11", "dev0 kept", int'(ldev_base[15:0]), 'h02E8);
    rd('h4F, "R11");

    // R4: exit
    cur_req = "R4";
    wr('h4E, 'hAA);
    chk("R4", "relocked", int'(cfg_unlocked), 0);
    wr('h4F, 'h00);
    rd_exp('h4F, 'hFF, "R5");
    wr('h4E, 'hA5);
    chk("R4", "one A5 after relock", int'(cfg_unlocked), 0);
    wr('h4E, 'h00);

    // R1: strapped alternate pair
    cur_req = "R1";
    @(negedge clk);
    strap_alt = 1'b1;
    wr('h4E, 'hA5);
    wr('h4E, 'hA5);
    chk("R1", "primary pair ignored when strap=1", int'(cfg_unlocked), 0);
    wr('h2E, 'hA5);
    wr('h2E, 'hA5);
    chk("R1", "alt pair unlocks", int'(cfg_unlocked), 1);
    set_reg('h2E, 'h07, 'h03);
    set_reg('h2E, 'h60, 'h12);
    set_reg('h2E, 'h61, 'h34);
    set_reg('h4E, 'h61, 'h99);
    chk("R1", "dev3 base via alt pair", int'(ldev_base[63:48]), 'h1234);
    rd('h2F, "R1");
    rd_exp('h4F, 'h00, "R1");
    wr('h2E, 'hAA);

    repeat (2) @(negedge clk);
    live = 0;
    summary();
    $finish;
  end
endmodule